// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the synchronised levels of several banks of general-purpose pins and raises one interrupt request when an enabled pin sees its chosen trigger. Three configuration bits per pin choose the trigger:

- **Edge mode bit.** Selects edge or level detection.
- **Polarity bit.** Selects rising or falling for edges, and high or low for levels.
- **Both-edges bit.** In edge mode, makes any change a trigger.

Every trigger hit is latched into a per-pin status bit. Software clears a status bit by writing a one to it.

A per-pin mask decides which status bits reach the request line. Software cannot write the mask directly. It changes the mask only through two write-only strobe registers: one clears mask bits (enables the pin), the other sets mask bits (disables the pin). A read-only copy of the mask shows its current value. The request output is the OR, over all banks, of the status bits whose mask bit is zero.

Access is through a simple register port with a byte address, a write strobe and a combinational read. The register window of bank N starts at byte address 0x200 + 0x40·N. Banks can be narrower than the data width. Pin positions beyond a bank's pin count never raise status.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Each mask bit reads 1 when the pin is masked. Writing ones to the enable register (bank offset 0x10) clears the matching mask bits. Writing ones to the disable register (bank offset 0x14) sets them. Zero bits in either write leave the mask unchanged. After reset every mask bit is 1, so writing all ones to each bank's disable register masks every pin.
- R2: With edge mode 1 and both-edges 0, a pin with polarity 1 sets its status bit on the clock edge where a 1 is sampled after a 0 on the previous cycle. With polarity 0, a 1-to-0 transition sets the status bit instead.
- R3: With edge mode 1 and both-edges 1, any change of the sampled level from one cycle to the next sets status. Polarity has no effect in this case.
- R4: With edge mode 0, polarity 1 sets status on every cycle the pin is sampled high, and polarity 0 on every cycle it is sampled low. Both-edges has no effect.
- R5: Writing ones to the status register (bank offset 0x18) clears those bits, and zero bits leave status unchanged. A trigger hit in the same cycle as the clear wins, so a held level keeps its status bit at 1.
- R6: Status bits latch trigger hits whether or not the pin is masked.
- R7: `irq` is 1 exactly when some bank has a status bit set whose mask bit is 0. It follows the registered state in the same cycle.
- R8: Edge mode (offset 0x1C), polarity (offset 0x20) and both-edges (offset 0x24) are read/write registers. A new value takes effect for trigger hits from the next clock edge on. Bits of absent pins always read 0.
- R9: Status bits of pin positions at or beyond a bank's pin count always read 0. Their mask bits always read 1.
- R10: Synchronous reset clears status and all trigger configuration and sets every mask bit. The previous-level register loads the current pin levels during reset, so no edge is seen on the first cycle after reset.
- R11: The mask copy is at bank offset 0x0C. The enable and disable registers read 0. Addresses outside the bank windows, or in the windows of absent banks, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NUM_BANKS*BANK_W | Synchronised pin levels, bank N in bits [N*BANK_W +: BANK_W] |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | BANK_W | Write data |
| reg_rdata | output | BANK_W | Combinational read data for reg_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with two banks eight bits wide, where the second bank has only six pins. With this configuration it can read back every register of every bank, plus two unmapped addresses, on every clock cycle. The absent pin positions of the second bank are inside the sweep. An eight-step rotation of trigger codes across the pins gives every pin position every combination of edge mode, polarity and both-edges, under sparse random pin toggling and interleaved clear, enable, disable, configuration and unmapped writes.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    // Bank register windows: base and stride (log2)
    localparam int unsigned WIN_BASE      = 'h200;
    localparam int unsigned WIN_STRIDE_LG = 6;

    // Register offsets inside one bank window
    localparam logic [5:0] OFS_MASK_RD = 6'h0C;
    localparam logic [5:0] OFS_UNMASK  = 6'h10;
    localparam logic [5:0] OFS_MASK    = 6'h14;
    localparam logic [5:0] OFS_STATUS  = 6'h18;
    localparam logic [5:0] OFS_MODE    = 6'h1C;
    localparam logic [5:0] OFS_POLAR   = 6'h20;
    localparam logic [5:0] OFS_BOTH    = 6'h24;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_RD,
        SEL_UNMASK,
        SEL_MASK,
        SEL_STATUS,
        SEL_MODE,
        SEL_POLAR,
        SEL_BOTH
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    typedef struct packed {
        logic edge_mode;
        logic rise;
        logic both;
    } trig_cfg_t;

    function automatic reg_sel_e sel_of(input logic [5:0] ofs);
        case (ofs)
            OFS_MASK_RD: return SEL_MASK_RD;
            OFS_UNMASK:  return SEL_UNMASK;
            OFS_MASK:    return SEL_MASK;
            OFS_STATUS:  return SEL_STATUS;
            OFS_MODE:    return SEL_MODE;
            OFS_POLAR:   return SEL_POLAR;
            OFS_BOTH:    return SEL_BOTH;
            default:     return SEL_NONE;
        endcase
    endfunction

    // One pin: does the configured trigger fire for this sample pair?
    function automatic logic trig_hit(input trig_cfg_t c, input logic cur, input logic prev);
        if (c.edge_mode) begin
            if (c.both) return cur ^ prev;
            return c.rise ? (cur & ~prev) : (~cur & prev);
        end
        return c.rise ? cur : ~cur;
    endfunction

endpackage

// File: rtl/gpio_irq_regdec.sv
`timescale 1ns/1ps
module gpio_irq_regdec
    import gpio_irq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output reg_dec_t             dec,
    output logic [NUM_BANKS-1:0] bank_sel
);
    localparam int unsigned WIN_W  = ADDR_W - WIN_STRIDE_LG;
    localparam int unsigned WIN_LO = WIN_BASE >> WIN_STRIDE_LG;

    logic [WIN_W-1:0] win;
    assign win = addr[ADDR_W-1:WIN_STRIDE_LG];

    always_comb begin
        bank_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (win == WIN_W'(WIN_LO + b)) bank_sel[b] = 1'b1;
        end
        dec.sel = sel_of(addr[WIN_STRIDE_LG-1:0]);
        dec.hit = (|bank_sel) && (dec.sel != SEL_NONE);
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned         BANK_W = 32,
    parameter logic [BANK_W-1:0]   VALID  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lvl,
    input  logic [BANK_W-1:0] mode,
    input  logic [BANK_W-1:0] polar,
    input  logic [BANK_W-1:0] both,
    output logic [BANK_W-1:0] hit
);
    logic [BANK_W-1:0] prev_q;

    // Loaded in reset as well, so the first cycle out of reset sees no edge
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    always_comb begin
        for (int i = 0; i < BANK_W; i++) begin
            hit[i] = VALID[i] & trig_hit(trig_cfg_t'{mode[i], polar[i], both[i]},
                                         lvl[i], prev_q[i]);
        end
    end

    // A single-direction edge cannot fire on two consecutive cycles
    assert_single_edge_R2: assert property (@(posedge clk) disable iff (rst)
        ($stable(mode) && $stable(polar) && $stable(both))
        |-> ((hit & $past(hit) & mode & ~both) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned BANK_W    = 32,
    parameter int unsigned PIN_COUNT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lvl,
    input  reg_sel_e          wr_sel,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] mask_o,
    output logic [BANK_W-1:0] sts_o,
    output logic [BANK_W-1:0] mode_o,
    output logic [BANK_W-1:0] polar_o,
    output logic [BANK_W-1:0] both_o,
    output logic              pend_o
);
    localparam logic [BANK_W-1:0] VALID = {BANK_W{1'b1}} >> (BANK_W - PIN_COUNT);

    logic [BANK_W-1:0] mask_q, sts_q, mode_q, polar_q, both_q;
    logic [BANK_W-1:0] hit;
    logic [BANK_W-1:0] clr;

    gpio_irq_detect #(.BANK_W(BANK_W), .VALID(VALID)) u_det (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl),
        .mode  (mode_q),
        .polar (polar_q),
        .both  (both_q),
        .hit   (hit)
    );

    assign clr = (wr_sel == SEL_STATUS) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            sts_q   <= '0;
            mode_q  <= '0;
            polar_q <= '0;
            both_q  <= '0;
        end else begin
            sts_q <= (sts_q & ~clr) | hit;
            case (wr_sel)
                SEL_UNMASK: mask_q  <= mask_q & ~(wdata & VALID);
                SEL_MASK:   mask_q  <= mask_q | wdata;
                SEL_MODE:   mode_q  <= wdata & VALID;
                SEL_POLAR:  polar_q <= wdata & VALID;
                SEL_BOTH:   both_q  <= wdata & VALID;
                default: ;
            endcase
        end
    end

    assign mask_o  = mask_q;
    assign sts_o   = sts_q;
    assign mode_o  = mode_q;
    assign polar_o = polar_q;
    assign both_o  = both_q;
    assign pend_o  = |(sts_q & ~mask_q);

    assert_unmask_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_UNMASK) |=> ((mask_q & $past(wdata & VALID)) == '0));

    assert_mask_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_MASK) |=> ((mask_q & $past(wdata)) == $past(wdata)));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_STATUS) |=> ((sts_q & $past(wdata & ~hit)) == '0));

    assert_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> ((sts_q & $past(hit)) == $past(hit)));

    assert_absent_R9: assert property (@(posedge clk) disable iff (rst)
        ((sts_q & ~VALID) == '0) && ((mask_q | VALID) == '1));

endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned              NUM_BANKS = 4,
    parameter int unsigned              BANK_W    = 32,
    parameter int unsigned              ADDR_W    = 10,
    parameter logic [NUM_BANKS*8-1:0]   BANK_PINS = {8'd32, 8'd32, 8'd22, 8'd32}
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_lvl,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr,
    input  logic [BANK_W-1:0]           reg_wdata,
    output logic [BANK_W-1:0]           reg_rdata,
    output logic                        irq
);
    reg_dec_t             dec;
    logic [NUM_BANKS-1:0] bank_sel;
    logic [NUM_BANKS-1:0] pend;
    logic [NUM_BANKS-1:0] all_masked;

    logic [BANK_W-1:0] rd_mask  [NUM_BANKS];
    logic [BANK_W-1:0] rd_sts   [NUM_BANKS];
    logic [BANK_W-1:0] rd_mode  [NUM_BANKS];
    logic [BANK_W-1:0] rd_polar [NUM_BANKS];
    logic [BANK_W-1:0] rd_both  [NUM_BANKS];

    gpio_irq_regdec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr     (reg_addr),
        .dec      (dec),
        .bank_sel (bank_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int unsigned PCNT = int'(BANK_PINS[b*8 +: 8]);
        reg_sel_e wsel;
        assign wsel = (reg_wr && dec.hit && bank_sel[b]) ? dec.sel : SEL_NONE;

        gpio_irq_bank #(.BANK_W(BANK_W), .PIN_COUNT(PCNT)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .lvl     (pin_lvl[b*BANK_W +: BANK_W]),
            .wr_sel  (wsel),
            .wdata   (reg_wdata),
            .mask_o  (rd_mask[b]),
            .sts_o   (rd_sts[b]),
            .mode_o  (rd_mode[b]),
            .polar_o (rd_polar[b]),
            .both_o  (rd_both[b]),
            .pend_o  (pend[b])
        );

        assign all_masked[b] = &rd_mask[b];
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && bank_sel[b]) begin
                case (dec.sel)
                    SEL_MASK_RD: reg_rdata = rd_mask[b];
                    SEL_STATUS:  reg_rdata = rd_sts[b];
                    SEL_MODE:    reg_rdata = rd_mode[b];
                    SEL_POLAR:   reg_rdata = rd_polar[b];
                    SEL_BOTH:    reg_rdata = rd_both[b];
                    default: ;
                endcase
            end
        end
    end

    assign irq = |pend;

    assert_quiet_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (&all_masked) |-> !irq);

    assert_strobe_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (dec.sel == SEL_UNMASK || dec.sel == SEL_MASK) |-> (reg_rdata == '0));

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int AW = 10;
    localparam logic [NB*8-1:0] PINS = {8'd6, 8'd8};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   pin_lvl = 16'h5AA5;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [BW-1:0] reg_wdata = '0;
    logic [BW-1:0] reg_rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(AW), .BANK_PINS(PINS)) u0 (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_mask [NB];
    logic [7:0] m_sts  [NB];
    logic [7:0] m_mode [NB];
    logic [7:0] m_pol  [NB];
    logic [7:0] m_both [NB];
    logic [7:0] m_prev [NB];
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [7:0] valid_of(input int b);
        return (b == 0) ? 8'hFF : 8'h3F;
    endfunction

    function automatic logic [AW-1:0] adr(input int b, input logic [5:0] ofs);
        return AW'(10'h200 + b * 10'h40 + ofs);
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model for one clock edge
    task automatic model_step(input logic wr, input logic [AW-1:0] a, input logic [7:0] d, input logic [15:0] p);
        for (int b = 0; b < NB; b++) begin
            logic [7:0] cur, ev, clr;
            cur = p[b*8 +: 8];
            ev  = '0;
            for (int i = 0; i < 8; i++) begin
                if (valid_of(b)[i]) begin
                    if (m_mode[b][i])
                        ev[i] = m_both[b][i] ? (cur[i] ^ m_prev[b][i])
                              : (m_pol[b][i] ? (cur[i] & ~m_prev[b][i]) : (~cur[i] & m_prev[b][i]));
                    else
                        ev[i] = m_pol[b][i] ? cur[i] : ~cur[i];
                end
            end
            clr = '0;
            if (wr && a[9:6] == 4'(8 + b)) begin
                case (a[5:0])
                    6'h10: m_mask[b] = m_mask[b] & ~(d & valid_of(b));
                    6'h14: m_mask[b] = m_mask[b] | d;
                    6'h18: clr = d;
                    6'h1C: m_mode[b] = d & valid_of(b);
                    6'h20: m_pol[b]  = d & valid_of(b);
                    6'h24: m_both[b] = d & valid_of(b);
                    default: ;
                endcase
            end
            m_sts[b]  = (m_sts[b] & ~clr) | ev;
            m_prev[b] = cur;
        end
    endtask

    task automatic check_regs(input string tag);
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 7; k++) begin
                logic [5:0] ofs;
                logic [7:0] exp;
                string req;
                case (k)
                    0: begin ofs = 6'h0C; exp = m_mask[b]; req = "R1"; end
                    1: begin ofs = 6'h10; exp = 8'h00;     req = "R11"; end
                    2: begin ofs = 6'h14; exp = 8'h00;     req = "R11"; end
                    3: begin ofs = 6'h18; exp = m_sts[b];  req = "R2 R3 R4 R5 R6"; end
                    4: begin ofs = 6'h1C; exp = m_mode[b]; req = "R8"; end
                    5: begin ofs = 6'h20; exp = m_pol[b];  req = "R8"; end
                    default: begin ofs = 6'h24; exp = m_both[b]; req = "R8"; end
                endcase
                reg_addr = adr(b, ofs);
                #0.1;
                chk({tag, req}, $sformatf("bank%0d ofs %h", b, ofs), reg_rdata, exp);
                if (b == 1 && k == 3) chk("R9", "absent pin status", reg_rdata & 8'hC0, 8'h00);
                if (b == 1 && k == 0) chk("R9", "absent pin mask", reg_rdata & 8'hC0, 8'hC0);
            end
        end
        reg_addr = 10'h298;
        #0.1;
        chk("R11", "absent bank read", reg_rdata, 8'h00);
        reg_addr = 10'h018;
        #0.1;
        chk("R11", "below window read", reg_rdata, 8'h00);
    endtask

    task automatic tick(input logic wr, input logic [AW-1:0] a, input logic [7:0] d, input logic [15:0] p);
        logic [7:0] exp_irq;
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        pin_lvl   = p;
        model_step(wr, a, d, p);
        @(posedge clk);
        #0.5;
        reg_wr = 1'b0;
        exp_irq = {7'd0, |((m_sts[0] & ~m_mask[0]) | (m_sts[1] & ~m_mask[1]))};
        chk("R7", "irq", {7'd0, irq}, exp_irq);
        check_regs("");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pins;
        pins = 16'h5AA5;
        for (int b = 0; b < NB; b++) begin
            m_mask[b] = 8'hFF; m_sts[b] = 8'h00; m_mode[b] = 8'h00;
            m_pol[b] = 8'h00;  m_both[b] = 8'h00; m_prev[b] = pins[b*8 +: 8];
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.2;
        check_regs("R10 ");

        // Zero-bit enable write must not unmask (R1), then unmask bank 0
        tick(1'b1, adr(0, 6'h10), 8'h00, pins);
        tick(1'b1, adr(0, 6'h10), 8'hFF, pins);
        // Held low level re-sets status across a clear (R4, R5)
        tick(1'b1, adr(0, 6'h18), 8'hFF, pins);
        chk("R5", "held level survives clear", m_sts[0] & ~pins[7:0], ~pins[7:0]);
        // Disable all pins of every bank (R1, R7)
        tick(1'b1, adr(0, 6'h14), 8'hFF, pins);
        tick(1'b1, adr(1, 6'h14), 8'hFF, pins);
        chk("R7", "irq after mask-all", {7'd0, irq}, 8'h00);

        for (int rot = 0; rot < 8; rot++) begin
            for (int b = 0; b < NB; b++) begin
                logic [7:0] md, pl, bo;
                for (int i = 0; i < 8; i++) begin
                    int code;
                    code  = (i + b + rot) % 8;
                    md[i] = code[0];
                    pl[i] = code[1];
                    bo[i] = code[2];
                end
                tick(1'b1, adr(b, 6'h1C), md, pins);
                tick(1'b1, adr(b, 6'h20), pl, pins);
                tick(1'b1, adr(b, 6'h24), bo, pins);
                tick(1'b1, adr(b, 6'h18), 8'hFF, pins);
                tick(1'b1, adr(b, 6'h10), 8'hFF, pins);
            end
            for (int n = 0; n < 100; n++) begin
                int bk;
                seed = nxt(seed);
                pins = pins ^ (seed[31:16] & seed[23:8]);
                bk   = int'(seed[3]);
                case (seed[2:0])
                    3'd0: tick(1'b1, adr(bk, 6'h18), seed[15:8], pins);
                    3'd1: tick(1'b1, adr(bk, 6'h18), 8'hFF, pins);
                    3'd2: tick(1'b1, adr(bk, 6'h10), seed[15:8], pins);
                    3'd3: tick(1'b1, adr(bk, 6'h14), seed[15:8] & seed[7:0], pins);
                    3'd4: tick(seed[4], adr(bk, 6'h1C), seed[15:8], pins);
                    3'd5: tick(seed[4], adr(bk, 6'h24), seed[15:8], pins);
                    3'd6: tick(1'b1, 10'h2D0, seed[15:8], pins);
                    default: tick(1'b0, adr(bk, 6'h20), seed[15:8], pins);
                endcase
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule